// File: doc/BRIEF.md
# Sign-Filling Right Shifter

This block shifts a two's-complement word to the right by a variable distance. The bits vacated at the top are filled with copies of the input's sign bit, so the result is the input divided by a power of two and rounded toward minus infinity. It is purely combinational: the output follows the data and the distance within the same evaluation, with no clock, no latency and no handshake. No back-pressure exists; a surrounding pipeline registers the result wherever it needs to.

The word width is a power of two. The distance input is the base-two logarithm of the width in bits. Internally the shift is built as a chain of fixed-distance stages. The stage with index i moves the word down by 2^i places when bit i of the distance is set, and passes the word through otherwise. Each output bit of a stage is a two-input multiplexer. Positions whose source would lie above the top of the word take the original sign bit.

Top module: `asr_cascade`

## Requirements
- R1: For every input word and distance d, output bit j equals input bit j+d when j+d is below WIDTH, and equals input bit WIDTH-1 otherwise.
- R2: A distance of zero returns the input word unchanged.
- R3: The most significant output bit always equals the most significant input bit.
- R4: An all-ones input yields an all-ones output for every distance.
- R5: A non-negative input (top bit 0) yields the unsigned quotient of the input by 2^d, with zeros entering from the top.
- R6: A negative input yields floor(value / 2^d), rounded toward minus infinity. For example, at WIDTH 4 the input 4'b1001 with distance 2'b10 gives 4'b1110.
- R7: Distance bit i alone moves the word by exactly 2^i places. Setting several distance bits applies the sum of their distances.
- R8: The largest distance, WIDTH-1, yields a word made entirely of copies of the sign bit.
- R9: The output settles in the same time step as its inputs change. No clock edge is involved.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | WIDTH | Two's-complement word to be shifted |
| shift_amt | input | $clog2(WIDTH) | Right-shift distance |
| data_out | output | WIDTH | Sign-filled shifted word |

## Verification
Two functions of the block act on the same word at once: moving surviving bits down, and filling the vacated top positions with the sign. Several stages can also be active together when more than one distance bit is set. Every pair of an 8-bit word and a distance is applied, so negative words with partial shifts exercise both the fill and the bit movement in one vector. Each result is judged against two references computed in the bench: a signed arithmetic shift, and an integer floor division by 2^d. A separate 4-bit instance confirms the small worked example.

// File: rtl/asr_pkg.sv
package asr_pkg;

  function automatic bit is_pow2(input int unsigned v);
    return (v != 0) && ((v & (v - 1)) == 0);
  endfunction

endpackage

// File: rtl/asr_mux2.sv
module asr_mux2 (
  input  logic keep_bit,
  input  logic moved_bit,
  input  logic pick_moved,
  output logic result
);
  assign result = pick_moved ? moved_bit : keep_bit;
endmodule

// File: rtl/asr_stage.sv
module asr_stage #(
  parameter int unsigned WIDTH = 32,
  parameter int unsigned DIST  = 1
) (
  input  logic [WIDTH-1:0] din,
  input  logic             sel,
  input  logic             fill,
  output logic [WIDTH-1:0] dout
);
  localparam int unsigned KEEP = WIDTH - DIST;

  for (genvar j = 0; j < WIDTH; j++) begin : g_bit
    if (j < KEEP) begin : g_inner
      asr_mux2 u_mux (
        .keep_bit  (din[j]),
        .moved_bit (din[j+DIST]),
        .pick_moved(sel),
        .result    (dout[j])
      );
    end else begin : g_edge
      asr_mux2 u_mux (
        .keep_bit  (din[j]),
        .moved_bit (fill),
        .pick_moved(sel),
        .result    (dout[j])
      );
    end
  end

  always_comb begin
    if (!sel) begin
      assert_stage_pass_R7: assert (dout == din);
    end else begin
      for (int j = KEEP; j < WIDTH; j++) begin
        assert_stage_fill_R7: assert (dout[j] == fill);
      end
    end
  end
endmodule

// File: rtl/asr_cascade.sv
module asr_cascade #(
  parameter int unsigned WIDTH = 32,
  localparam int unsigned SHW  = $clog2(WIDTH)
) (
  input  logic [WIDTH-1:0] data_in,
  input  logic [SHW-1:0]   shift_amt,
  output logic [WIDTH-1:0] data_out
);
  import asr_pkg::*;

  localparam logic [WIDTH-1:0] ALL_ONES = {WIDTH{1'b1}};

  logic [WIDTH-1:0] lane [SHW+1];
  logic             sign_bit;

  assign sign_bit = data_in[WIDTH-1];
  assign lane[0]  = data_in;

  for (genvar i = 0; i < SHW; i++) begin : g_stage
    asr_stage #(
      .WIDTH(WIDTH),
      .DIST (1 << i)
    ) u_stage (
      .din (lane[i]),
      .sel (shift_amt[i]),
      .fill(sign_bit),
      .dout(lane[i+1])
    );
  end

  assign data_out = lane[SHW];

  initial begin
    assert_width_pow2_R1: assert (is_pow2(WIDTH) && WIDTH >= 2);
  end

  always_comb begin
    assert_sign_kept_R3: assert (data_out[WIDTH-1] == data_in[WIDTH-1]);
    if (shift_amt == '0) begin
      assert_zero_shift_R2: assert (data_out == data_in);
    end
    if (data_in == ALL_ONES) begin
      assert_ones_stay_R4: assert (data_out == ALL_ONES);
    end
    if (data_in == '0) begin
      assert_zero_stays_R5: assert (data_out == '0);
    end
  end
endmodule

// File: tb/asr_cascade_test.sv
module asr_cascade_test;
  localparam int W  = 8;
  localparam int SW = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic [W-1:0]  x;
  logic [SW-1:0] sa;
  logic [W-1:0]  y;

  logic [3:0] x4;
  logic [1:0] sa4;
  logic [3:0] y4;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  asr_cascade #(.WIDTH(W)) uut (.data_in(x), .shift_amt(sa), .data_out(y));
  asr_cascade #(.WIDTH(4)) uut_w4 (.data_in(x4), .shift_amt(sa4), .data_out(y4));

  task automatic check(input bit ok, input string tag, input logic [W-1:0] act,
                       input logic [W-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s x=%b sa=%0d actual=%b expected=%b", tag, x, sa, act, exp);
    end
  endtask

  function automatic int floor_div(input int v, input int d);
    if (v >= 0) return v / d;
    return -((-v + d - 1) / d);
  endfunction

  initial begin
    x = '0; sa = '0; x4 = '0; sa4 = '0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9: reset-time all-zero inputs give zero at once
    check(y == '0, "R9", y, '0);

    for (int xi = 0; xi < (1 << W); xi++) begin
      for (int s = 0; s < W; s++) begin
        @(posedge clk);
        x  = W'(xi);
        sa = SW'(s);
        @(negedge clk);
        begin
          logic [W-1:0] ref_shift;
          logic [W-1:0] ref_bits;
          logic [W-1:0] ref_div;
          int sv;
          ref_shift = W'($signed(x) >>> s);
          for (int j = 0; j < W; j++)
            ref_bits[j] = (j + s < W) ? x[j+s] : x[W-1];
          sv = int'($signed(x));
          ref_div = W'(floor_div(sv, 1 << s));
          // R1: bitwise definition with sign fill
          check(y == ref_bits, "R1", y, ref_bits);
          // R7: combined stages equal the total distance
          check(y == ref_shift, "R7", y, ref_shift);
          // R3: top bit preserved
          check(y[W-1] == x[W-1], "R3", {7'b0, y[W-1]}, {7'b0, x[W-1]});
          if (x[W-1]) check(y == ref_div, "R6", y, ref_div);
          else        check(y == (x >> s), "R5", y, x >> s);
          if (s == 0)     check(y == x, "R2", y, x);
          if (s == W - 1) check(y == {W{x[W-1]}}, "R8", y, {W{x[W-1]}});
          if (x == '1)    check(y == '1, "R4", y, '1);
        end
      end
    end

    // R6: worked example at width 4, 1001 >> 2 gives 1110
    @(posedge clk);
    x4 = 4'b1001; sa4 = 2'b10;
    @(negedge clk);
    check(y4 == 4'b1110, "R6", {4'b0, y4}, 8'b0000_1110);

    // R9: output follows input change without a clock edge
    x = 8'b1000_0000; sa = 3'd3;
    #1;
    check(y == 8'b1111_0000, "R9", y, 8'b1111_0000);

    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired R9 actual=hung expected=done");
      end
    join_any
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule